// File: doc/BRIEF.md
# USB Data Packet Integrity Checker

This block sits behind a byte-wide USB receive interface: an active level that frames a packet, a valid strobe per byte and eight data bits. It checks a received data packet and strips its framing. The first byte is taken as the packet identifier. Its upper nibble must be the ones' complement of its lower nibble. The last two bytes are a CRC16 trailer. Every byte between them is forwarded as payload, one cycle after the byte that proves it is not part of the trailer has arrived.

A CRC16 register starts from all ones and uses the polynomial x^16+x^15+x^2+1. Each payload byte enters it with its bit order reversed. The trailer the block expects is that register's final value sent high byte first, with each byte bit-reversed and then inverted. The block also keeps the expected data toggle, DATA0 or DATA1. The toggle advances after every packet that arrives clean. A pulse on `setup_done`, raised when a control setup stage completes, forces the toggle to DATA1.

In the cycle after the active level falls, the block raises a one-cycle end strobe. In that same cycle it presents the received identifier, the payload length and three error flags.

Top module: `usb_dpkt_checker`

## Requirements
- R1: A byte is taken only at a clock edge where `rx_active` and `rx_valid` are both high. The first byte taken in a packet is the identifier, and its low nibble appears on `pkt_pid` during `pkt_end`.
- R2: `pid_bad` is high during `pkt_end` when bits 7:4 of the identifier byte differ from the complement of bits 3:0.
- R3: The CRC register is reset to 0xFFFF while `rx_active` is low. It is then updated with every payload byte, each bit-reversed, using the polynomial 0x8005 and shifting MSB first.
- R4: `crc_bad` is high during `pkt_end` when the second-to-last byte differs from the inverted, bit-reversed CRC bits 15:8, or when the last byte differs from the inverted, bit-reversed CRC bits 7:0.
- R5: Byte k of a packet (k counted from 0, with 1 ≤ k ≤ N-3 for an N-byte packet) appears on `pay_data` with `pay_valid` high for one cycle. That cycle is the one after the edge that takes byte k+2. No other cycle has `pay_valid` high.
- R6: `pkt_end` is high for exactly the one cycle after the first edge at which `rx_active` is sampled low following a high sample. `pkt_len` then equals N-3. Outside that cycle, `pkt_pid`, `pkt_len` and the three flags read zero.
- R7: A packet with fewer than three bytes sets `crc_bad` and reports `pkt_len` 0.
- R8: The expected toggle is DATA0 (code 0011) after reset. DATA1 is code 1011. `seq_bad` is high during `pkt_end` when the identifier's low nibble differs from the expected code.
- R9: The expected toggle changes between DATA0 and DATA1 after a packet that has `pid_bad`, `crc_bad` and `seq_bad` all low. After any other packet it stays the same.
- R10: `setup_done` high at a clock edge sets the expected toggle to DATA1. This takes priority over the change in R9.
- R11: While `rst_n` is low, every output is zero.
- R12: Bytes presented with `rx_valid` low, or while `rx_active` is low, leave the payload, the length and the CRC check unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | High while a packet is being received |
| rx_valid | input | 1 | Byte strobe for `rx_data` |
| rx_data | input | 8 | Received byte |
| setup_done | input | 1 | Forces the expected toggle to DATA1 |
| pay_data | output | 8 | Payload byte |
| pay_valid | output | 1 | `pay_data` is valid this cycle |
| pkt_end | output | 1 | One-cycle end-of-packet strobe |
| pkt_pid | output | 4 | Received identifier code, during `pkt_end` |
| pkt_len | output | LEN_W | Payload byte count, during `pkt_end` |
| pid_bad | output | 1 | Identifier check failed |
| crc_bad | output | 1 | Trailer mismatch or short packet |
| seq_bad | output | 1 | Data toggle mismatch |

## Verification
The hardest case to reach is a packet whose CRC is correct but whose toggle is wrong. It must be followed by a packet that arrives while the expected toggle has been held back, and by a setup pulse that overrides the toggle history. This only shows at the ports on the following packet. The stimulus therefore builds packets with correct trailers in the bench and places them in a fixed sequence: clean DATA0, clean DATA1, a correctly sealed packet with the wrong toggle, a corrupted trailer, then a setup pulse. A behavioural model tracks the expected toggle and checks every output on every cycle. Byte bubbles, bytes offered while the packet is idle, and packets of zero to three bytes cover the framing edges.

// File: rtl/usb_dpkt_pkg.sv
package usb_dpkt_pkg;
   localparam logic [3:0] PID_DATA0 = 4'b0011;
   localparam logic [3:0] PID_DATA1 = 4'b1011;

   function automatic logic [7:0] bitrev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction
endpackage

// File: rtl/dpkt_crc16.sv
module dpkt_crc16 #(
   parameter logic [15:0] POLY = 16'h8005,
   parameter logic [15:0] SEED = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear_i,
   input  logic        en_i,
   input  logic [7:0]  byte_i,
   output logic [15:0] crc_o
);
   import usb_dpkt_pkg::*;

   logic [15:0] crc_q;
   logic [15:0] crc_nx;

   always_comb begin
      logic [7:0] din;
      logic       fb;
      din    = bitrev8(byte_i);
      crc_nx = crc_q;
      for (int i = 7; i >= 0; i--) begin
         fb     = crc_nx[15] ^ din[i];
         crc_nx = {crc_nx[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) crc_q <= SEED;
      else if (en_i)         crc_q <= crc_nx;
   end

   assign crc_o = crc_q;

   AST_SEED_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (crc_q == SEED)); // R3
endmodule

// File: rtl/dpkt_tail.sv
module dpkt_tail (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear_i,
   input  logic        cap_i,
   input  logic        pass_i,
   input  logic [7:0]  byte_i,
   output logic        emit_o,
   output logic [7:0]  emit_byte_o,
   output logic [15:0] tail_o,
   output logic        out_valid_o,
   output logic [7:0]  out_byte_o
);
   logic [7:0] old_q, new_q;

   assign emit_o      = cap_i & pass_i;
   assign emit_byte_o = old_q;
   assign tail_o      = {old_q, new_q};

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         old_q <= '0;
         new_q <= '0;
      end else if (cap_i) begin
         old_q <= new_q;
         new_q <= byte_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         out_byte_o  <= '0;
      end else begin
         out_valid_o <= emit_o;
         if (emit_o) out_byte_o <= old_q;
      end
   end
endmodule

// File: rtl/dpkt_toggle.sv
module dpkt_toggle (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       setup_i,
   input  logic       done_i,
   input  logic       ok_i,
   output logic [3:0] expect_o
);
   import usb_dpkt_pkg::*;

   logic phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                phase_q <= 1'b0;
      else if (setup_i)          phase_q <= 1'b1;
      else if (done_i && ok_i)   phase_q <= ~phase_q;
   end

   assign expect_o = phase_q ? PID_DATA1 : PID_DATA0;

   AST_SETUP_FORCES_DATA1: assert property (@(posedge clk) disable iff (!rst_n)
      setup_i |=> (expect_o == PID_DATA1)); // R10
   AST_FLIP_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && ok_i && !setup_i) |=> (expect_o != $past(expect_o))); // R9
   AST_HOLD_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !ok_i && !setup_i) |=> $stable(expect_o)); // R9
endmodule

// File: rtl/usb_dpkt_checker.sv
module usb_dpkt_checker #(
   parameter int          LEN_W    = 11,
   parameter logic [15:0] CRC_POLY = 16'h8005,
   parameter logic [15:0] CRC_SEED = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_active,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             setup_done,
   output logic [7:0]       pay_data,
   output logic             pay_valid,
   output logic             pkt_end,
   output logic [3:0]       pkt_pid,
   output logic [LEN_W-1:0] pkt_len,
   output logic             pid_bad,
   output logic             crc_bad,
   output logic             seq_bad
);
   import usb_dpkt_pkg::*;

   localparam logic [LEN_W-1:0] FRAME_BYTES = LEN_W'(3);
   localparam logic [LEN_W-1:0] CNT_MAX     = {LEN_W{1'b1}};

   if (LEN_W < 3) begin : g_len_chk
      $error("LEN_W must be at least 3");
   end
   if (CRC_POLY[0] != 1'b1) begin : g_poly_chk
      $error("CRC_POLY must have its constant term set");
   end

   logic             act_q;
   logic [LEN_W-1:0] cnt_q;
   logic [7:0]       pid_q;
   logic             cap_w, end_w, pass_w, short_w;
   logic             emit_w;
   logic [7:0]       emit_byte_w;
   logic [15:0]      tail_w, crc_w, want_w;
   logic [3:0]       expect_w;
   logic             pid_fail_w, crc_fail_w, seq_fail_w;

   assign cap_w   = rx_active & rx_valid;
   assign end_w   = act_q & ~rx_active;
   assign pass_w  = (cnt_q >= FRAME_BYTES);
   assign short_w = (cnt_q < FRAME_BYTES);

   dpkt_tail u_tail (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (~rx_active),
      .cap_i       (cap_w),
      .pass_i      (pass_w),
      .byte_i      (rx_data),
      .emit_o      (emit_w),
      .emit_byte_o (emit_byte_w),
      .tail_o      (tail_w),
      .out_valid_o (pay_valid),
      .out_byte_o  (pay_data)
   );

   dpkt_crc16 #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (~rx_active),
      .en_i    (emit_w),
      .byte_i  (emit_byte_w),
      .crc_o   (crc_w)
   );

   assign want_w     = {~bitrev8(crc_w[15:8]), ~bitrev8(crc_w[7:0])};
   assign pid_fail_w = (pid_q[7:4] != ~pid_q[3:0]);
   assign crc_fail_w = short_w | (tail_w != want_w);
   assign seq_fail_w = (pid_q[3:0] != expect_w);

   dpkt_toggle u_tog (
      .clk      (clk),
      .rst_n    (rst_n),
      .setup_i  (setup_done),
      .done_i   (end_w),
      .ok_i     (~(pid_fail_w | crc_fail_w | seq_fail_w)),
      .expect_o (expect_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
         pid_q <= '0;
      end else begin
         act_q <= rx_active;
         if (!rx_active) begin
            cnt_q <= '0;
            pid_q <= '0;
         end else if (cap_w) begin
            if (cnt_q == '0)     pid_q <= rx_data;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !end_w) begin
         pkt_end <= 1'b0;
         pkt_pid <= '0;
         pkt_len <= '0;
         pid_bad <= 1'b0;
         crc_bad <= 1'b0;
         seq_bad <= 1'b0;
      end else begin
         pkt_end <= 1'b1;
         pkt_pid <= pid_q[3:0];
         pkt_len <= short_w ? '0 : cnt_q - FRAME_BYTES;
         pid_bad <= pid_fail_w;
         crc_bad <= crc_fail_w;
         seq_bad <= seq_fail_w;
      end
   end

   AST_PAY_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |-> $past(rx_active && rx_valid)); // R5
   AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end |=> !pkt_end); // R6
   AST_FLAGS_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_end |-> !(pid_bad || crc_bad || seq_bad)); // R6
   AST_SHORT_IS_CRC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (end_w && short_w) |=> (crc_bad && pkt_len == '0)); // R7
endmodule

// File: tb/usb_dpkt_checker_tb_top.sv
module usb_dpkt_checker_tb_top;
   localparam int LEN_W = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_active = 1'b0, rx_valid = 1'b0, setup_done = 1'b0;
   logic [7:0]       rx_data = '0;
   logic [7:0]       pay_data;
   logic             pay_valid, pkt_end, pid_bad, crc_bad, seq_bad;
   logic [3:0]       pkt_pid;
   logic [LEN_W-1:0] pkt_len;

   always #4 clk = ~clk;

   usb_dpkt_checker #(.LEN_W(LEN_W)) dut_i (.*);

   int vectors = 0, errors = 0, cycles = 0;
   logic [7:0] q[$];
   logic       m_act = 1'b0;
   logic [3:0] m_expect = 4'b0011;
   logic       e_ov = 0, e_end = 0, e_pb = 0, e_cb = 0, e_sb = 0;
   logic [7:0] e_ob = 0;
   logic [3:0] e_pid = 0;
   int         e_len = 0;
   logic       last_cb = 0, last_sb = 0, last_pb = 0;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] ref_crc(input int first, input int last);
      logic [15:0] c = 16'hFFFF;
      for (int k = first; k <= last; k++)
         for (int b = 0; b < 8; b++) begin
            logic fb = c[15] ^ q[k][b];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h8005;
         end
      return c;
   endfunction

   function automatic logic [7:0] flipinv(input logic [7:0] x);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[7-i] = ~x[i];
      return r;
   endfunction

   // behavioural model: compute outputs expected after the coming edge
   task automatic model(input logic a, input logic v, input logic [7:0] d, input logic s);
      logic [7:0]  pb;
      logic [15:0] c;
      int          n;
      logic        ok;
      e_ov = 0; e_end = 0; e_pb = 0; e_cb = 0; e_sb = 0; e_pid = 0; e_len = 0;
      ok = 0;
      if (a && v) begin
         if (q.size() >= 3) begin e_ov = 1; e_ob = q[q.size()-2]; end
         q.push_back(d);
      end
      if (!a && m_act) begin
         n = q.size();
         pb = (n >= 1) ? q[0] : 8'h00;
         e_end = 1; e_pid = pb[3:0];
         e_pb = (pb[7:4] != ~pb[3:0]);
         e_sb = (pb[3:0] != m_expect);
         if (n < 3) e_cb = 1;
         else begin
            c = ref_crc(1, n-3);
            e_cb = (q[n-2] != flipinv(c[15:8])) || (q[n-1] != flipinv(c[7:0]));
            e_len = n - 3;
         end
         ok = !(e_pb || e_cb || e_sb);
      end
      if (s) m_expect = 4'b1011;
      else if (ok) m_expect = m_expect ^ 4'b1000;
      if (!a) q.delete();
      m_act = a;
   endtask

   task automatic step(input logic a, input logic v, input logic [7:0] d, input logic s);
      rx_active = a; rx_valid = v; rx_data = d; setup_done = s;
      model(a, v, d, s);
      @(posedge clk);
      @(negedge clk);
      chk(pay_valid == e_ov, "R5 pay_valid", pay_valid, e_ov);
      if (e_ov) chk(pay_data == e_ob, "R5 pay_data", pay_data, e_ob);
      chk(pkt_end == e_end, "R6 pkt_end", pkt_end, e_end);
      chk(pkt_pid == e_pid, "R1 pkt_pid", pkt_pid, e_pid);
      chk(int'(pkt_len) == e_len, "R6 pkt_len", pkt_len, e_len);
      chk(pid_bad == e_pb, "R2 pid_bad", pid_bad, e_pb);
      chk(crc_bad == e_cb, "R4 crc_bad", crc_bad, e_cb);
      chk(seq_bad == e_sb, "R8 seq_bad", seq_bad, e_sb);
      if (pkt_end) begin last_cb = crc_bad; last_sb = seq_bad; last_pb = pid_bad; end
   endtask

   logic [7:0] pk[$];

   task automatic build(input logic [7:0] pid, input int len, input int seed, input logic spoil);
      logic [15:0] c = 16'hFFFF;
      pk.delete();
      pk.push_back(pid);
      for (int i = 0; i < len; i++) begin
         logic [7:0] b = 8'((seed + i * 37) ^ (i << 3));
         pk.push_back(b);
         for (int k = 0; k < 8; k++) begin
            logic fb = c[15] ^ b[k];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h8005;
         end
      end
      pk.push_back(flipinv(c[15:8]));
      pk.push_back(flipinv(c[7:0]) ^ (spoil ? 8'h10 : 8'h00));
   endtask

   task automatic send(input int bubble);
      foreach (pk[i]) begin
         if (bubble != 0 && (i % bubble) == 1) step(1, 0, 8'hA5, 0);
         step(1, 1, pk[i], 0);
      end
      step(0, 0, 8'h00, 0);
      step(0, 0, 8'h00, 0);
   endtask

   initial begin : watchdog
      while (cycles < 20000) begin @(posedge clk); cycles++; end
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk({pay_valid, pkt_end, pid_bad, crc_bad, seq_bad} == 5'b0, "R11 flags in reset",
          {pay_valid, pkt_end, pid_bad, crc_bad, seq_bad}, 0);
      chk(pkt_len == '0 && pkt_pid == '0, "R11 len/pid in reset", pkt_len, 0);
      rst_n = 1'b1;
      step(0, 0, 0, 0);
      // R12: valid while inactive is ignored
      step(0, 1, 8'h4B, 0); step(0, 1, 8'h12, 0);
      // R3 R4: clean DATA0 with bubbles
      build(8'hC3, 4, 1, 0); send(2);
      chk(last_cb == 0 && last_sb == 0, "R3 clean DATA0", last_cb, 0);
      // R9: now DATA1 expected
      build(8'h4B, 7, 9, 0); send(0);
      chk(last_sb == 0, "R9 toggled to DATA1", last_sb, 0);
      // toggle mismatch with correct CRC, expectation must hold
      build(8'h4B, 3, 5, 0); send(3);
      chk(last_sb == 1, "R8 seq mismatch", last_sb, 1);
      build(8'hC3, 5, 77, 1); send(0);
      chk(last_cb == 1, "R4 bad trailer", last_cb, 1);
      build(8'hC3, 2, 3, 0); send(0);
      chk(last_sb == 0 && last_cb == 0, "R9 held after errors", last_sb, 0);
      // PID check
      build(8'h33, 2, 4, 0); send(0);
      chk(last_pb == 1, "R2 pid nibble", last_pb, 1);
      // R7: short packets of 2, 1 and 0 bytes
      pk.delete(); pk.push_back(8'h4B); pk.push_back(8'h00); send(0);
      chk(last_cb == 1, "R7 two bytes", last_cb, 1);
      pk.delete(); pk.push_back(8'h4B); send(0);
      chk(last_cb == 1, "R7 one byte", last_cb, 1);
      pk.delete(); step(1, 0, 8'h55, 0); send(0);
      chk(last_cb == 1, "R7 zero bytes", last_cb, 1);
      // R10: setup forces DATA1
      step(0, 0, 0, 1); step(0, 0, 0, 0);
      build(8'h4B, 8, 21, 0); send(0);
      chk(last_sb == 0, "R10 DATA1 after setup", last_sb, 0);
      // empty payload, 3 bytes total (DATA0 now expected)
      build(8'hC3, 0, 0, 0); send(0);
      chk(last_cb == 0, "R6 zero-length payload", last_cb, 0);
      // setup on the end cycle of a clean packet wins over the flip
      build(8'h4B, 6, 50, 0);
      foreach (pk[i]) step(1, 1, pk[i], 0);
      step(0, 0, 0, 1); step(0, 0, 0, 0);
      build(8'h4B, 2, 8, 0); send(0);
      chk(last_sb == 0, "R10 priority over flip", last_sb, 0);
      // long packet with bubbles
      build(8'hC3, 40, 13, 0); send(5);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule